// File: doc/BRIEF.md
# Variable Machine-Cycle SYNC Generator

This block shapes processor machine cycles out of a free-running oscillator clock. Each accepted request starts one machine cycle. Its length and its SYNC high time are fixed by a cycle kind given with the request. There are five kinds: a 5-clock cycle with 3 clocks high (P), two 5-clock bus cycles (I/O and M), and two 6-clock cycles, one with 3 clocks high (B1) and one with 4 clocks high (B2). A sequencer upstream presents one request per step and tags it with a kind. The block answers with a one-clock start pulse, the SYNC level and a one-clock end pulse.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high while the block is idle, and on the last clock of a running cycle. It is low on every other clock. A requester that is held off must keep `req_valid` and `req_kind` steady until the request is taken. A request taken on the last clock of a cycle starts the next cycle on the following clock, with no idle clock in between. Once a kind has been taken, it governs the whole cycle, whatever `req_kind` does afterwards.

Top module: `msync_gen`

## Requirements
- R1: While reset is asserted and on the first clock after it, `sync_out`, `cyc_start` and `cyc_end` are low and `req_ready` is high.
- R2: Kind code 0 (P) gives a cycle of 5 clocks with SYNC high on the first 3 and low on the last 2.
- R3: Kind codes 1 (I/O) and 2 (M) each give a cycle of 5 clocks with SYNC high on the first 3 and low on the last 2.
- R4: Kind code 3 (B1) gives a cycle of 6 clocks with SYNC high on the first 3 and low on the last 3.
- R5: Kind code 4 (B2) gives a cycle of 6 clocks with SYNC high on the first 4 and low on the last 2.
- R6: `cyc_start` is high for exactly the first clock of each cycle. That clock directly follows the edge on which the request was taken.
- R7: `cyc_end` is high for exactly the last clock of each cycle. `req_ready` is high on that clock and while idle, and low on every other clock of a cycle.
- R8: A request taken on the end clock starts a new cycle on the very next clock, so SYNC cycles follow each other without a gap.
- R9: Changes on `req_kind` after a request is taken do not alter the running cycle. This holds with `req_valid` low, and also while a new request waits. `cur_kind` shows the kind that was taken.
- R10: When no request is taken, the block stays idle: SYNC low and no start or end pulse.
- R11: Kind codes 5, 6 and 7 are treated as code 0 (P): 5 clocks, 3 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A cycle request is offered |
| req_ready | output | 1 | The block takes the offered request on this edge |
| req_kind | input | 3 | Cycle kind of the offered request (0 P, 1 I/O, 2 M, 3 B1, 4 B2) |
| cyc_start | output | 1 | High on the first clock of a machine cycle |
| sync_out | output | 1 | SYNC level of the machine cycle |
| cyc_end | output | 1 | High on the last clock of a machine cycle |
| cur_kind | output | 3 | Kind of the running cycle |

## Verification
A request taken on edge k gives `cyc_start` and SYNC high in the clock after edge k. The end pulse falls in that cycle's clock 5 or 6, and from there a request that is waiting starts the next cycle one edge later. The driver pushes the whole per-clock expectation of a cycle into a queue on the same half-clock in which it sees `req_ready` high, which is before the edge that takes the request. The monitor samples 2 ns after every rising edge and pops exactly one entry per clock. An empty queue means an idle clock is expected. Because of this, any extra or missing clock in a cycle shifts every later comparison and is caught.

// File: rtl/msync_pkg.sv
package msync_pkg;

  typedef enum logic [2:0] {
    KIND_P  = 3'd0,
    KIND_IO = 3'd1,
    KIND_M  = 3'd2,
    KIND_B1 = 3'd3,
    KIND_B2 = 3'd4
  } cyc_kind_e;

  // Codes outside the defined set fall back to the P kind.
  function automatic cyc_kind_e kind_of(input logic [2:0] code);
    cyc_kind_e k;
    case (code)
      3'd1:    k = KIND_IO;
      3'd2:    k = KIND_M;
      3'd3:    k = KIND_B1;
      3'd4:    k = KIND_B2;
      default: k = KIND_P;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/msync_shape.sv
module msync_shape
  import msync_pkg::*;
#(
  parameter int SHORT_LEN = 5,
  parameter int LONG_LEN  = 6,
  parameter int P_HIGH    = 3,
  parameter int IO_HIGH   = 3,
  parameter int M_HIGH    = 3,
  parameter int B1_HIGH   = 3,
  parameter int B2_HIGH   = 4,
  parameter int CNT_W     = 3
) (
  input  cyc_kind_e        kind,
  output logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] high
);

  always_comb begin
    case (kind)
      KIND_IO: begin len = CNT_W'(SHORT_LEN); high = CNT_W'(IO_HIGH); end
      KIND_M:  begin len = CNT_W'(SHORT_LEN); high = CNT_W'(M_HIGH);  end
      KIND_B1: begin len = CNT_W'(LONG_LEN);  high = CNT_W'(B1_HIGH); end
      KIND_B2: begin len = CNT_W'(LONG_LEN);  high = CNT_W'(B2_HIGH); end
      default: begin len = CNT_W'(SHORT_LEN); high = CNT_W'(P_HIGH);  end
    endcase
  end

endmodule

// File: rtl/msync_timer.sv
module msync_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len_in,
  input  logic [CNT_W-1:0] high_in,
  output logic             active,
  output logic             first,
  output logic             last,
  output logic             sync_lvl
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] high_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      len_q  <= '0;
      high_q <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= '0;
      len_q  <= len_in;
      high_q <= high_in;
    end else if (active) begin
      if (last) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign first    = active && (cnt == '0);
  assign last     = active && (cnt == len_q - CNT_W'(1));
  assign sync_lvl = active && (cnt < high_q);

  // R10: an idle timer drives neither SYNC nor an end pulse
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!sync_lvl && !last));

  // R6: every cycle opens with SYNC high
  assert_start_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    first |-> sync_lvl);

  // R8: after an end clock comes either a fresh first clock or idle
  assert_end_then_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (first || !active));

  // R2: SYNC only falls inside a running cycle, never on its first clock
  assert_fall_inside_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_lvl) |-> (!first || !active));

endmodule

// File: rtl/msync_gen.sv
module msync_gen
  import msync_pkg::*;
#(
  parameter int SHORT_LEN = 5,
  parameter int LONG_LEN  = 6,
  parameter int P_HIGH    = 3,
  parameter int IO_HIGH   = 3,
  parameter int M_HIGH    = 3,
  parameter int B1_HIGH   = 3,
  parameter int B2_HIGH   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [2:0] req_kind,
  output logic       cyc_start,
  output logic       sync_out,
  output logic       cyc_end,
  output logic [2:0] cur_kind
);

  localparam int MAX_LEN = (SHORT_LEN > LONG_LEN) ? SHORT_LEN : LONG_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  cyc_kind_e        in_kind;
  cyc_kind_e        kind_q;
  logic [CNT_W-1:0] len_w;
  logic [CNT_W-1:0] high_w;
  logic             active;
  logic             take;

  assign in_kind = kind_of(req_kind);

  msync_shape #(
    .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN),
    .P_HIGH(P_HIGH), .IO_HIGH(IO_HIGH), .M_HIGH(M_HIGH),
    .B1_HIGH(B1_HIGH), .B2_HIGH(B2_HIGH), .CNT_W(CNT_W)
  ) u_shape (
    .kind (in_kind),
    .len  (len_w),
    .high (high_w)
  );

  msync_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .len_in   (len_w),
    .high_in  (high_w),
    .active   (active),
    .first    (cyc_start),
    .last     (cyc_end),
    .sync_lvl (sync_out)
  );

  assign req_ready = !active || cyc_end;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)    kind_q <= KIND_P;
    else if (take) kind_q <= in_kind;
  end

  assign cur_kind = kind_q;

  // R6: a taken request opens a cycle on the next clock
  assert_take_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cyc_start);

  // R7: a request that is held off opens nothing
  assert_held_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !cyc_start);

  // R9: the taken kind stays put for the rest of the cycle
  assert_kind_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cyc_start) |-> $stable(cur_kind));

  // R10: with no request taken an idle block stays idle
  assert_stay_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !req_valid) |=> !cyc_start);

endmodule

// File: tb/msync_gen_tb.sv
`timescale 1ns/1ps
module msync_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic       req_ready, cyc_start, sync_out, cyc_end;
  logic [2:0] cur_kind;

  int total = 0;
  int bad = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    bit [3:0] v;     // {start, sync, end, ready}
    bit [2:0] kind;
    string    tag;
  } exp_t;

  exp_t exp_q[$];

  always #4 clk = ~clk;

  msync_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .cyc_start(cyc_start), .sync_out(sync_out),
    .cyc_end(cyc_end), .cur_kind(cur_kind)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Driver: offer a request, queue its expected trace once it will be taken.
  task automatic issue(input bit [2:0] k, input string tag);
    int len, high;
    bit [2:0] ek;
    req_valid = 1'b1;
    req_kind  = k;
    while (!req_ready) @(negedge clk);
    case (k)
      3'd3:    begin len = 6; high = 3; end
      3'd4:    begin len = 6; high = 4; end
      default: begin len = 5; high = 3; end
    endcase
    ek = (k > 3'd4) ? 3'd0 : k;
    for (int i = 0; i < len; i++) begin
      exp_t it;
      it.v[3] = (i == 0);
      it.v[2] = (i < high);
      it.v[1] = (i == len - 1);
      it.v[0] = (i == len - 1);
      it.kind = ek;
      it.tag  = (i == 0) ? {"R6 ", tag} : (i == len - 1) ? {"R7 ", tag} : tag;
      exp_q.push_back(it);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: one comparison per clock, 2 ns after the rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_on) begin
        bit [3:0] act;
        act = {cyc_start, sync_out, cyc_end, req_ready};
        if (exp_q.size() == 0) begin
          check(act == 4'b0001, "R10 idle", int'(act), 1);
        end else begin
          exp_t it;
          it = exp_q.pop_front();
          check(act == it.v, it.tag, int'(act), int'(it.v));
          check(cur_kind == it.kind, {"R9 kind ", it.tag}, int'(cur_kind), int'(it.kind));
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet outputs and ready during reset
    check({cyc_start, sync_out, cyc_end, req_ready} == 4'b0001, "R1 in reset",
          int'({cyc_start, sync_out, cyc_end, req_ready}), 1);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    check({cyc_start, sync_out, cyc_end, req_ready} == 4'b0001, "R1 after reset",
          int'({cyc_start, sync_out, cyc_end, req_ready}), 1);

    issue(3'd0, "R2");
    idle(3);
    issue(3'd1, "R3");
    idle(2);
    issue(3'd2, "R3");
    issue(3'd3, "R4 R8");
    issue(3'd4, "R5 R8");
    idle(4);

    // R9: kind input wiggles with valid low during a B2 cycle
    issue(3'd4, "R9");
    for (int j = 0; j < 3; j++) begin
      req_kind = 3'(j);
      @(negedge clk);
    end
    idle(4);
    // R9: a waiting request of another kind must not reshape the running one
    issue(3'd4, "R9");
    issue(3'd0, "R9 R8");

    idle(2);
    issue(3'd7, "R11");
    issue(3'd5, "R11");
    issue(3'd6, "R11");
    idle(3);
    issue(3'd3, "R8");
    issue(3'd4, "R8");
    issue(3'd1, "R8");

    // R10: long idle stretch with kind changing and no valid
    for (int j = 0; j < 10; j++) begin
      req_kind = 3'(j);
      @(negedge clk);
    end
    wait (exp_q.size() == 0);
    idle(3);
    finish_up();
  end

endmodule